// File: doc/BRIEF.md
# Vector-Feedback Mismatch-Shaping Element Selector

The block turns a 5-bit level code into a 32-bit on/off mask for 32 nominally equal DAC unit elements. The number of set mask bits always equals the code. The choice of elements is driven by each element's filtered usage history, so the error caused by element mismatch is moved out of a narrow band centred on one quarter of the sample rate. Each element has its own loop filter, and every filter sees only the one-bit "was I selected" feedback. The filter is a cascade of two resonators with poles at Fs/4. Each resonator is built from a two-sample delay, and the coefficients are powers of two. Together the two resonators form a fourth-order band-pass section.

A minimizer takes the least filter output and subtracts it from every entry. A separate ranking block then registers this vector and turns on the elements with the largest entries. Equal entries are resolved toward the lower index. The ranking block adds one pipeline stage. To keep the loop delay short, the filter output is taken from the node ahead of its state register. As a result, the mask chosen for one code influences the selection made two codes later.

Top module: `dem_mask_shaper`

## Requirements
- R1: The population count of `mask_o` equals the code sampled two rising edges earlier. The code is sampled at edge t, and the mask appears after edge t+1.
- R2: Code 0 produces an all-zero mask. Code 31 produces a mask with exactly one clear bit.
- R3: An asynchronous low on `rst_ni` clears the mask at once and zeroes all element histories. Codes of 0 leave the histories at zero. The first non-zero code c after reset yields the mask 2^c-1, which is the lowest c indices.
- R4: When entries are equal, the lower element index wins. With no history, code 1 gives 0x00000001 and a following code 9 gives 0x000001FF.
- R5: A mask is first seen by the selection made two codes later. With code 4 held from reset, the first three masks are 0x0000000F, 0x0000000F, 0x000000F0. The code sequence 4, 0, 4 gives 0x0000000F, 0x00000000, 0x000000F0.
- R6: After the minimizer, every entry is non-negative and the least entry is zero. Elements with identical histories therefore compare equal and fall back to index order. Code 31 held from reset gives a third mask of 0xBFFFFFFF.
- R7: The element filters resonate at Fs/4. With code 4 held from reset, the fourth mask is 0x000000F0 and the fifth mask returns to 0x0000000F.
- R8: Feedback to each filter is a single bit. An element that has never been selected keeps a zero history and stays tied with the other unused elements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, one code per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 5 | Number of elements to turn on |
| mask_o | output | 32 | Element on/off mask, bit k drives element k |

## Verification
Two things can happen in the same cycle. A mask leaves the ranking stage and, through the pre-register tap, enters the filters. In that same cycle the ranking stage registers a vector that must not yet include that mask. Constant codes and gapped codes are applied straight after reset, so the exact masks show whether the feedback arrives one cycle early, one cycle late, or on time. Full-scale codes and codes of 1 and 9 set up ties that only the index order can resolve. A long random code stream, combined with an asynchronous reset in the middle of a run, checks that the population count holds whatever the history is and that the histories restart cleanly.

// File: rtl/dem_pkg.sv
package dem_pkg;
  localparam int DEM_N_ELEM    = 32;
  localparam int DEM_STATE_W   = 12;
  localparam int DEM_ONE_SHIFT = 4;  // one-bit feedback weight 2**ONE_SHIFT
  localparam int DEM_FB_SHIFT  = 2;  // resonator-to-resonator feedback 2**-FB_SHIFT
  localparam int DEM_OUT_SHIFT = 1;  // second resonator output weight 2**-OUT_SHIFT
endpackage

// File: rtl/dem_elem_filter.sv
module dem_elem_filter #(
  parameter int STATE_W   = 12,
  parameter int ONE_SHIFT = 4,
  parameter int FB_SHIFT  = 2,
  parameter int OUT_SHIFT = 1,
  localparam int EXT_W    = STATE_W + 2,
  localparam int SF_W     = STATE_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sel_i,
  output logic signed [SF_W-1:0] sf_o
);
  localparam logic signed [EXT_W-1:0] ONE_V = EXT_W'(1) <<< ONE_SHIFT;
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'((2 ** (STATE_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MIN_V = -MAX_V - EXT_W'(1);

  function automatic logic signed [STATE_W-1:0] sat(input logic signed [EXT_W-1:0] x);
    if (x > MAX_V)      sat = MAX_V[STATE_W-1:0];
    else if (x < MIN_V) sat = MIN_V[STATE_W-1:0];
    else                sat = x[STATE_W-1:0];
  endfunction

  // each resonator holds w[n-1] in q and w[n-2] in p: w = in - w[n-2]
  logic signed [STATE_W-1:0] p1_q, q1_q, p2_q, q2_q;
  logic signed [STATE_W-1:0] w1, w2;
  logic signed [EXT_W-1:0]   fb_x, in1_x, w1_x, w2_x;

  always_comb begin
    fb_x  = sel_i ? -ONE_V : '0;
    in1_x = fb_x - EXT_W'(q2_q >>> FB_SHIFT);
    w1_x  = in1_x - EXT_W'(p1_q);
    w1    = sat(w1_x);
    w2_x  = EXT_W'(w1) - EXT_W'(p2_q);
    w2    = sat(w2_x);
    // pre-register tap: current feedback reaches the output this cycle
    sf_o  = SF_W'(w1) + SF_W'(w2 >>> OUT_SHIFT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
      q1_q <= '0;
      p2_q <= '0;
      q2_q <= '0;
    end else begin
      q1_q <= w1;
      p1_q <= q1_q;
      q2_q <= w2;
      p2_q <= q2_q;
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1_q == '0 && q1_q == '0 && p2_q == '0 && q2_q == '0 && !sel_i)
    |=> (p1_q == '0 && q1_q == '0 && p2_q == '0 && q2_q == '0));
endmodule

// File: rtl/dem_vec_min.sv
module dem_vec_min #(
  parameter int N_ELEM = 32,
  parameter int SF_W   = 13,
  localparam int SY_W  = SF_W + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [SF_W-1:0] sf_i [N_ELEM],
  output logic signed [SY_W-1:0] sy_o [N_ELEM]
);
  logic signed [SF_W-1:0] min_v;
  logic neg_any, zero_any;

  always_comb begin
    min_v = sf_i[0];
    for (int i = 1; i < N_ELEM; i++) begin
      if (sf_i[i] < min_v) min_v = sf_i[i];
    end
    for (int i = 0; i < N_ELEM; i++) begin
      sy_o[i] = SY_W'(sf_i[i]) - SY_W'(min_v);
    end
  end

  always_comb begin
    neg_any  = 1'b0;
    zero_any = 1'b0;
    for (int i = 0; i < N_ELEM; i++) begin
      neg_any  = neg_any | sy_o[i][SY_W-1];
      zero_any = zero_any | (sy_o[i] == '0);
    end
  end

  // R6
  sy_nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !neg_any);
  // R6
  sy_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) zero_any);
endmodule

// File: rtl/dem_rank_sel.sv
module dem_rank_sel #(
  parameter int N_ELEM  = 32,
  parameter int SY_W    = 14,
  localparam int CODE_W = $clog2(N_ELEM)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CODE_W-1:0]      code_i,
  input  logic signed [SY_W-1:0] sy_i [N_ELEM],
  output logic [N_ELEM-1:0]      mask_o
);
  logic signed [SY_W-1:0] sy_r [N_ELEM];
  logic [CODE_W-1:0]      code_r;
  logic [N_ELEM-1:0]      sel_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_r <= '0;
      for (int i = 0; i < N_ELEM; i++) sy_r[i] <= '0;
    end else begin
      code_r <= code_i;
      for (int i = 0; i < N_ELEM; i++) sy_r[i] <= sy_i[i];
    end
  end

  // rank = entries ahead of k; ties go to the lower index
  for (genvar k = 0; k < N_ELEM; k++) begin : g_rank
    logic [CODE_W:0] rank;
    always_comb begin
      rank = '0;
      for (int j = 0; j < N_ELEM; j++) begin
        if (j != k) begin
          if (sy_r[j] > sy_r[k] || (sy_r[j] == sy_r[k] && j < k))
            rank = rank + (CODE_W+1)'(1);
        end
      end
    end
    assign sel_c[k] = rank < {1'b0, code_r};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= '0;
    else         mask_o <= sel_c;
  end

  // R1
  pop_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mask_o) == int'($past(code_r)));
endmodule

// File: rtl/dem_mask_shaper.sv
module dem_mask_shaper
  import dem_pkg::*;
#(
  parameter int N_ELEM    = DEM_N_ELEM,
  parameter int STATE_W   = DEM_STATE_W,
  parameter int ONE_SHIFT = DEM_ONE_SHIFT,
  parameter int FB_SHIFT  = DEM_FB_SHIFT,
  parameter int OUT_SHIFT = DEM_OUT_SHIFT,
  localparam int CODE_W   = $clog2(N_ELEM),
  localparam int SF_W     = STATE_W + 1,
  localparam int SY_W     = SF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic [N_ELEM-1:0] mask_o
);
  logic signed [SF_W-1:0] sf [N_ELEM];
  logic signed [SY_W-1:0] sy [N_ELEM];

  for (genvar k = 0; k < N_ELEM; k++) begin : g_elem
    dem_elem_filter #(
      .STATE_W  (STATE_W),
      .ONE_SHIFT(ONE_SHIFT),
      .FB_SHIFT (FB_SHIFT),
      .OUT_SHIFT(OUT_SHIFT)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sel_i (mask_o[k]),
      .sf_o  (sf[k])
    );
  end

  dem_vec_min #(
    .N_ELEM(N_ELEM),
    .SF_W  (SF_W)
  ) u_min (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sf_i  (sf),
    .sy_o  (sy)
  );

  dem_rank_sel #(
    .N_ELEM(N_ELEM),
    .SY_W  (SY_W)
  ) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(code_i),
    .sy_i  (sy),
    .mask_o(mask_o)
  );
endmodule

// File: tb/dem_mask_shaper_tb_top.sv
module dem_mask_shaper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  code = '0;
  logic [31:0] mask;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // slot0 = code driven last step, slot1 = the step before
  bit v0, v1, x0, x1;
  logic [4:0]  c0, c1;
  logic [31:0] e0, e1;
  string t0, t1;

  always #2.5 clk = ~clk;

  dem_mask_shaper dut_i (.clk_i(clk), .rst_ni(rst_n), .code_i(code), .mask_o(mask));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic clear_slots();
    v0 = 0; v1 = 0; x0 = 0; x1 = 0;
  endtask

  task automatic step(input logic [4:0] c, input bit exact, input logic [31:0] exp_m,
                      input string req);
    @(negedge clk);
    if (v1) begin
      chk($countones(mask) == int'(c1), "R1", "popcount", 32'($countones(mask)), 32'(c1));
      if (x1) chk(mask == e1, t1, "mask", mask, e1);
    end
    v1 = v0; x1 = x0; c1 = c0; e1 = e0; t1 = t0;
    v0 = 1;  x0 = exact; c0 = c; e0 = exp_m; t0 = req;
    code = c;
  endtask

  task automatic flush();
    step(5'd0, 1'b1, 32'h0, "R2");
    step(5'd0, 1'b1, 32'h0, "R2");
    step(5'd0, 1'b0, 32'h0, "R2");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    code  = '0;
    clear_slots();
    #1 chk(mask == 32'h0, "R3", "mask in reset", mask, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    repeat (3) @(negedge clk);
    chk(mask == 32'h0, "R3", "idle after reset", mask, 32'h0);
  endtask

  task automatic t_const4();
    do_reset();
    step(5'd4, 1'b1, 32'h0000000F, "R3");
    step(5'd4, 1'b1, 32'h0000000F, "R5");
    step(5'd4, 1'b1, 32'h000000F0, "R5 R8");
    step(5'd4, 1'b1, 32'h000000F0, "R7");
    step(5'd4, 1'b1, 32'h0000000F, "R7");
    flush();
  endtask

  task automatic t_gap();
    do_reset();
    step(5'd4, 1'b1, 32'h0000000F, "R5");
    step(5'd0, 1'b1, 32'h00000000, "R2");
    step(5'd4, 1'b1, 32'h000000F0, "R5");
    flush();
  endtask

  task automatic t_full();
    do_reset();
    step(5'd31, 1'b1, 32'h7FFFFFFF, "R2");
    step(5'd31, 1'b1, 32'h7FFFFFFF, "R2");
    step(5'd31, 1'b1, 32'hBFFFFFFF, "R6 R4");
    flush();
  endtask

  task automatic t_tie();
    do_reset();
    step(5'd1, 1'b1, 32'h00000001, "R4");
    step(5'd9, 1'b1, 32'h000001FF, "R4");
    flush();
  endtask

  task automatic t_random(input int n);
    for (int i = 0; i < n; i++) begin
      step(5'($urandom_range(0, 31)), 1'b0, 32'h0, "R1");
    end
    for (int i = 0; i < 40; i++) begin
      step((i % 2) ? 5'd31 : 5'd0, 1'b0, 32'h0, "R2");
    end
    flush();
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 40; i++) step(5'($urandom_range(8, 31)), 1'b0, 32'h0, "R1");
    @(negedge clk);
    rst_n = 1'b0;
    code  = '0;
    clear_slots();
    #1 chk(mask == 32'h0, "R3", "async clear", mask, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(5'd3, 1'b1, 32'h00000007, "R3");
    step(5'd3, 1'b1, 32'h00000007, "R3");
    step(5'd3, 1'b1, 32'h00000038, "R5");
    flush();
  endtask

  initial begin
    clear_slots();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_const4();
    t_gap();
    t_full();
    t_tie();
    t_random(3000);
    t_midreset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule